// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block sits beside a processor core and decides, every cycle, whether an exception should interrupt the code that is running. It watches a parameterized set of peripheral request lines plus two fixed system exceptions: a non-maskable interrupt and a hard fault. For each peripheral line it keeps an enable bit, a pending bit, an active bit and a programmable priority. A rising request marks an exception pending. The most urgent eligible pending exception is offered to the core, and it is offered only when its priority beats the priority of whatever is already executing.

The offer is a valid/ready pair. `take_valid` with `take_num` says that an exception should be entered now. The core accepts it by raising `take_ready` in the same cycle. The offer is a live decision rather than a queued item. It may change number or drop while `take_ready` is low, for example when a more urgent request arrives or a mask is written. Nothing is consumed until both signals are high together. The core signals a handler's completion with a one-cycle `exc_return` pulse.

Configuration covers several controls: a global mask for programmable exceptions, a priority threshold, a priority-grouping split that separates preemption from ordering, and a sleep-on-exit option that asks the core to sleep instead of dropping back to thread level. All of these live behind a plain write port and a combinational read port.

Top module: `npic_top`

## Requirements
- R1: After reset, all peripheral enable, pending, active and priority fields are zero, the control register reads 0, `take_valid` and `sleep_req` are 0 and `take_num` is 0.
- R2: Exception numbers are fixed. The non-maskable interrupt is 1, the hard fault is 2 and peripheral line i is 16+i. `take_num` is 0 whenever `take_valid` is 0.
- R3: A 0-to-1 transition on a request line sets its pending bit, and a line held high does not set it again. Writing the per-line register sets pending to bit 1 of the written data. A rising edge in the same cycle as a write still leaves pending set.
- R4: Each candidate gets an urgency key. The non-maskable interrupt counts as -2, the hard fault as -1 and a peripheral as its programmed priority, where a lower value is more urgent. Among eligible pending exceptions, the lowest key wins, and on equal keys the lowest exception number wins.
- R5: An exception is offered only when its group priority is numerically strictly lower than the running priority. The running priority is the group priority of the most urgent active exception. When nothing is active, it is a thread level below every programmable priority.
- R6: The split field (control bits [6:4]) gives the number of low priority bits that act as sub-priority. It is clamped to PRIO_BITS-1 on write. Only the remaining high bits (the group priority) decide preemption. Sub-priority still orders candidates.
- R7: The threshold field (control bits [8+:PRIO_BITS]) blocks every peripheral whose priority is greater than or equal to its value. A value of zero disables the threshold. The two fixed exceptions are never blocked by it.
- R8: The global mask (control bit 0) blocks every peripheral exception and never blocks the non-maskable interrupt or the hard fault.
- R9: A cycle with `take_valid` and `take_ready` both high clears the offered exception's pending bit and sets its active bit. The same exception is not offered in the following cycle.
- R10: An `exc_return` pulse clears the active bit of the most urgent active exception. Offers made from the next cycle on use the recomputed running priority.
- R11: With sleep-on-exit (control bit 1) set, a return that leaves no exception active, accepts nothing in that cycle and has no eligible pending exception raises `sleep_req` on the next cycle. `sleep_req` falls in the cycle after an offer appears.
- R12: Peripheral line i has a register at address 0x100+i. Bit 0 is the enable, bit 1 is pending, bit 2 is active (read-only) and bits [8+:PRIO_BITS] hold the priority. The control register is at address 0x000. A pending but disabled line is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Peripheral request lines, edge detected |
| nmi_in | input | 1 | Non-maskable interrupt request, edge detected |
| hfault_in | input | 1 | Hard fault request, edge detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write address |
| wdata | input | 16 | Register write data |
| rd_addr | input | 9 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| take_valid | output | 1 | An exception should be entered now |
| take_ready | input | 1 | Core accepts the offered exception |
| take_num | output | 8 | Offered exception number |
| exc_return | input | 1 | One-cycle pulse at handler completion |
| sleep_req | output | 1 | Sleep request issued on exit to thread level |

## Verification
The hardest situation to reach is a comparison between a new candidate and a nonzero running priority while priority grouping is active. It requires an exception that is already active, a second one pending behind it, and a split that hides some of the priority bits. The bench builds it through the ports. It pends one line, accepts it with the handshake, and then pends a second line. It sweeps both priorities and several split values, and computes arithmetically whether the group parts allow nesting. Return-to-inner behaviour and sleep-on-exit are reached the same way, by stacking two or three accepted exceptions and unwinding them with return pulses.

// File: rtl/npic_pkg.sv
package npic_pkg;
  localparam int unsigned EXC_W  = 8;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned DATA_W = 16;

  localparam logic [EXC_W-1:0]  EXC_NMI    = 8'd1;
  localparam logic [EXC_W-1:0]  EXC_HFAULT = 8'd2;
  localparam logic [EXC_W-1:0]  IRQ_BASE   = 8'd16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 9'h000;
  localparam logic [ADDR_W-1:0] ADDR_IRQ0  = 9'h100;

  // Slot 0 is the non-maskable interrupt, slot 1 the hard fault,
  // slot 2+i the peripheral line i.
  function automatic logic [EXC_W-1:0] exc_of_slot(input int unsigned slot);
    if (slot == 0) return EXC_NMI;
    if (slot == 1) return EXC_HFAULT;
    return EXC_W'(slot - 2) + IRQ_BASE;
  endfunction
endpackage

// File: rtl/npic_prio_arb.sv
module npic_prio_arb #(
  parameter int unsigned N    = 18,
  parameter int unsigned KW   = 4,
  parameter int unsigned IW   = 5
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][KW-1:0] key,
  output logic                 any,
  output logic [IW-1:0]        idx,
  output logic [KW-1:0]        best
);
  // Strictly-lower comparison keeps the lowest index on equal keys.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i] && (!any || (key[i] < best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = key[i];
      end
    end
  end
endmodule

// File: rtl/npic_cfg_regs.sv
module npic_cfg_regs
  import npic_pkg::*;
#(
  parameter int unsigned PRIO_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 gmask,
  output logic                 sleep_en,
  output logic [2:0]           split,
  output logic [PRIO_BITS-1:0] thr,
  output logic [DATA_W-1:0]    rd_word
);
  localparam logic [2:0] SPLIT_MAX = 3'(PRIO_BITS - 1);

  logic wdata_unused;
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask    <= 1'b0;
      sleep_en <= 1'b0;
      split    <= '0;
      thr      <= '0;
    end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
      gmask    <= wdata[0];
      sleep_en <= wdata[1];
      split    <= (wdata[6:4] > SPLIT_MAX) ? SPLIT_MAX : wdata[6:4];
      thr      <= wdata[8 +: PRIO_BITS];
    end
  end

  always_comb begin
    rd_word                  = '0;
    rd_word[0]               = gmask;
    rd_word[1]               = sleep_en;
    rd_word[6:4]             = split;
    rd_word[8 +: PRIO_BITS]  = thr;
  end
endmodule

// File: rtl/npic_irq_bank.sv
module npic_irq_bank
  import npic_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 16,
  parameter int unsigned PRIO_BITS = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_IRQ-1:0]                  irq_in,
  input  logic                                nmi_in,
  input  logic                                hfault_in,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wdata,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [NUM_IRQ+1:0]                  take_hit,
  input  logic [NUM_IRQ+1:0]                  ret_hit,
  output logic [NUM_IRQ+1:0]                  pend,
  output logic [NUM_IRQ+1:0]                  act,
  output logic [NUM_IRQ+1:0]                  en,
  output logic [NUM_IRQ+1:0][PRIO_BITS-1:0]   prio,
  output logic [DATA_W-1:0]                   rd_word
);
  localparam int unsigned NUM_SLOT = NUM_IRQ + 2;

  logic [NUM_SLOT-1:0] raw;
  assign raw = {irq_in, hfault_in, nmi_in};

  logic wdata_unused;
  assign wdata_unused = ^wdata;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic                 sel;
    logic                 rise;
    logic                 prev_q;
    logic                 pend_q;
    logic                 act_q;
    logic                 en_q;
    logic [PRIO_BITS-1:0] prio_q;

    if (g < 2) begin : g_fixed
      // Fixed exceptions: always enabled, not software addressable.
      assign sel = 1'b0;
    end else begin : g_periph
      assign sel = wr_en && (wr_addr == (ADDR_IRQ0 + ADDR_W'(g - 2)));
    end

    assign rise = raw[g] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
        act_q  <= 1'b0;
        en_q   <= (g < 2) ? 1'b1 : 1'b0;
        prio_q <= '0;
      end else begin
        prev_q <= raw[g];
        pend_q <= rise | (sel ? wdata[1] : (pend_q & ~take_hit[g]));
        act_q  <= (act_q | take_hit[g]) & ~ret_hit[g];
        if (sel) begin
          en_q   <= wdata[0];
          prio_q <= wdata[8 +: PRIO_BITS];
        end
      end
    end

    assign pend[g] = pend_q;
    assign act[g]  = act_q;
    assign en[g]   = en_q;
    assign prio[g] = prio_q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(NUM_IRQ); i++) begin
      if (rd_addr == (ADDR_IRQ0 + ADDR_W'(i))) begin
        rd_word[0]              = en[i+2];
        rd_word[1]              = pend[i+2];
        rd_word[2]              = act[i+2];
        rd_word[8 +: PRIO_BITS] = prio[i+2];
      end
    end
  end
endmodule

// File: rtl/npic_top.sv
module npic_top
  import npic_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 16,
  parameter int unsigned PRIO_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               hfault_in,
  input  logic               wr_en,
  input  logic [8:0]         wr_addr,
  input  logic [15:0]        wdata,
  input  logic [8:0]         rd_addr,
  output logic [15:0]        rd_data,
  output logic               take_valid,
  input  logic               take_ready,
  output logic [7:0]         take_num,
  input  logic               exc_return,
  output logic               sleep_req
);
  localparam int unsigned NUM_SLOT = NUM_IRQ + 2;
  localparam int unsigned IDX_W    = $clog2(NUM_SLOT);
  localparam int unsigned KEY_W    = PRIO_BITS + 1;
  localparam logic [KEY_W-1:0] THREAD_KEY = KEY_W'((1 << PRIO_BITS) + 2);

  // Key encoding: 0 = non-maskable, 1 = hard fault, prio+2 = peripheral.
  function automatic logic [KEY_W-1:0] group_key(input logic [KEY_W-1:0] k,
                                                 input logic [PRIO_BITS-1:0] m);
    logic [PRIO_BITS-1:0] p;
    p = PRIO_BITS'(k - KEY_W'(2));
    if (k < KEY_W'(2)) return k;
    return KEY_W'(p & m) + KEY_W'(2);
  endfunction

  logic                 cfg_gmask;
  logic                 cfg_sleep_en;
  logic [2:0]           cfg_split;
  logic [PRIO_BITS-1:0] cfg_thr;
  logic [15:0]          cfg_word;

  npic_cfg_regs #(.PRIO_BITS(PRIO_BITS)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wdata    (wdata),
    .gmask    (cfg_gmask),
    .sleep_en (cfg_sleep_en),
    .split    (cfg_split),
    .thr      (cfg_thr),
    .rd_word  (cfg_word)
  );

  logic [NUM_SLOT-1:0]                 take_hit;
  logic [NUM_SLOT-1:0]                 ret_hit;
  logic [NUM_SLOT-1:0]                 bank_pend;
  logic [NUM_SLOT-1:0]                 bank_act;
  logic [NUM_SLOT-1:0]                 bank_en;
  logic [NUM_SLOT-1:0][PRIO_BITS-1:0]  bank_prio;
  logic [15:0]                         bank_word;

  npic_irq_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .nmi_in    (nmi_in),
    .hfault_in (hfault_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wdata     (wdata),
    .rd_addr   (rd_addr),
    .take_hit  (take_hit),
    .ret_hit   (ret_hit),
    .pend      (bank_pend),
    .act       (bank_act),
    .en        (bank_en),
    .prio      (bank_prio),
    .rd_word   (bank_word)
  );

  assign rd_data = (rd_addr == ADDR_CTRL) ? cfg_word : bank_word;

  // Urgency keys and eligibility
  logic [NUM_SLOT-1:0][KEY_W-1:0] slot_key;
  logic [NUM_SLOT-1:0]            elig;
  logic [PRIO_BITS-1:0]           grp_mask;

  assign grp_mask = {PRIO_BITS{1'b1}} << cfg_split;

  always_comb begin
    for (int i = 0; i < int'(NUM_SLOT); i++) begin
      logic [KEY_W-1:0] pkey;
      logic             thr_block;
      pkey      = KEY_W'(bank_prio[i]) + KEY_W'(2);
      thr_block = (cfg_thr != '0) && (bank_prio[i] >= cfg_thr);
      if (i < 2) begin
        slot_key[i] = KEY_W'(i);
        elig[i]     = bank_pend[i] & bank_en[i];
      end else begin
        slot_key[i] = pkey;
        elig[i]     = bank_pend[i] & bank_en[i] & ~cfg_gmask & ~thr_block;
      end
    end
  end

  logic             cand_any;
  logic [IDX_W-1:0] cand_idx;
  logic [KEY_W-1:0] cand_best;
  logic             act_any;
  logic [IDX_W-1:0] act_idx;
  logic [KEY_W-1:0] act_best;

  npic_prio_arb #(.N(NUM_SLOT), .KW(KEY_W), .IW(IDX_W)) cand_arb_i (
    .req  (elig),
    .key  (slot_key),
    .any  (cand_any),
    .idx  (cand_idx),
    .best (cand_best)
  );

  npic_prio_arb #(.N(NUM_SLOT), .KW(KEY_W), .IW(IDX_W)) act_arb_i (
    .req  (bank_act),
    .key  (slot_key),
    .any  (act_any),
    .idx  (act_idx),
    .best (act_best)
  );

  // Preemption decision
  logic [KEY_W-1:0]     run_key;
  logic                 take_fire;
  logic [PRIO_BITS-1:0] cand_prio;

  assign run_key    = act_any ? group_key(act_best, grp_mask) : THREAD_KEY;
  assign take_valid = cand_any && (group_key(cand_best, grp_mask) < run_key);
  assign take_fire  = take_valid && take_ready;
  assign take_num   = take_valid ? exc_of_slot(32'(cand_idx)) : '0;
  assign cand_prio  = PRIO_BITS'(cand_best - KEY_W'(2));

  always_comb begin
    take_hit = '0;
    ret_hit  = '0;
    if (take_fire) take_hit[cand_idx] = 1'b1;
    if (exc_return && act_any) ret_hit[act_idx] = 1'b1;
  end

  // Sleep-on-exit
  logic last_exit;
  logic sleep_set;

  assign last_exit = exc_return && act_any && ((bank_act & ~ret_hit) == '0);
  assign sleep_set = last_exit && cfg_sleep_en && !cand_any && !take_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_req <= 1'b0;
    end else if (sleep_set) begin
      sleep_req <= 1'b1;
    end else if (take_valid) begin
      sleep_req <= 1'b0;
    end
  end
endmodule

// File: rtl/npic_chk.sv
module npic_chk #(
  parameter int unsigned PRIO_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 nmi_in,
  input logic                 take_valid,
  input logic                 take_ready,
  input logic [7:0]           take_num,
  input logic                 exc_return,
  input logic                 sleep_req,
  input logic                 gmask,
  input logic                 nmi_pend,
  input logic                 nmi_act,
  input logic [PRIO_BITS-1:0] thr,
  input logic [PRIO_BITS-1:0] cand_prio
);
  a_r2_idle_num: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> (take_num == 8'd0));

  a_r4_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_in) && !nmi_pend && !nmi_act) |=> (take_valid && take_num == 8'd1));

  a_r7_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_num >= 8'd16 && thr != '0) |-> (cand_prio < thr));

  a_r8_gmask_fixed_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && gmask) |-> (take_num < 8'd16));

  a_r9_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !(take_valid && take_num == $past(take_num)));

  a_r11_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(exc_return));

  a_r11_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && take_valid) |=> !sleep_req);
endmodule

bind npic_top npic_chk #(.PRIO_BITS(PRIO_BITS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_in     (nmi_in),
  .take_valid (take_valid),
  .take_ready (take_ready),
  .take_num   (take_num),
  .exc_return (exc_return),
  .sleep_req  (sleep_req),
  .gmask      (cfg_gmask),
  .nmi_pend   (bank_pend[0]),
  .nmi_act    (bank_act[0]),
  .thr        (cfg_thr),
  .cand_prio  (cand_prio)
);

// File: tb/npic_top_tb_top.sv
module npic_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;
  localparam int PB    = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_in = '0;
  logic            nmi_in = 1'b0;
  logic            hfault_in = 1'b0;
  logic            wr_en = 1'b0;
  logic [8:0]      wr_addr = '0;
  logic [15:0]     wdata = '0;
  logic [8:0]      rd_addr = '0;
  logic [15:0]     rd_data;
  logic            take_valid;
  logic            take_ready = 1'b0;
  logic [7:0]      take_num;
  logic            exc_return = 1'b0;
  logic            sleep_req;

  int checks = 0;
  int errors = 0;

  npic_top #(.NUM_IRQ(NIRQ), .PRIO_BITS(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .hfault_in(hfault_in), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .take_valid(take_valid),
    .take_ready(take_ready), .take_num(take_num), .exc_return(exc_return),
    .sleep_req(sleep_req)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 9'(a); wdata = 16'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic irq_reg(input int i, input int e, input int p, input int pr);
    wr(256 + i, (pr << 8) | (p << 1) | e);
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 9'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic take();
    take_ready = 1'b1; tick(); take_ready = 1'b0;
  endtask

  task automatic ret();
    exc_return = 1'b1; tick(); exc_return = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 take_valid", int'(take_valid), 0);
    check("R1 sleep_req", int'(sleep_req), 0);
    check("R2 take_num idle", int'(take_num), 0);
    rd(0, v);   check("R1 ctrl", v, 0);
    rd(256, v); check("R1 irq0 reg", v, 0);

    // R4 ordering sweep: two lines, all priority pairs, split 0
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        irq_reg(0, 1, 1, a);
        irq_reg(1, 1, 1, b);
        check("R4 winner", int'(take_num), (a <= b) ? 16 : 17);
        irq_reg(0, 0, 0, 0);
        irq_reg(1, 0, 0, 0);
      end
    end

    // R7 threshold sweep
    for (int t = 0; t < 8; t++) begin
      for (int p = 0; p < 8; p++) begin
        wr(0, t << 8);
        irq_reg(0, 1, 1, p);
        check("R7 threshold", int'(take_valid), (t == 0 || p < t) ? 1 : 0);
        irq_reg(0, 0, 0, 0);
      end
    end
    wr(0, 0);

    // R5/R6 nesting sweep over split and both priorities
    for (int s = 0; s < 3; s++) begin
      wr(0, s << 4);
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          irq_reg(0, 1, 1, a);
          take();
          irq_reg(1, 1, 1, b);
          check("R6 group nesting", int'(take_valid), ((b >> s) < (a >> s)) ? 1 : 0);
          irq_reg(1, 0, 0, 0);
          ret();
          check("R5 thread after return", int'(take_valid), 0);
        end
      end
    end

    // R6 clamp and sub-priority ordering
    wr(0, 7 << 4);
    rd(0, v); check("R6 split clamp", (v >> 4) & 7, 2);
    irq_reg(0, 1, 1, 3);
    irq_reg(1, 1, 1, 1);
    irq_reg(2, 1, 1, 1);
    check("R6 sub-priority winner", int'(take_num), 17);
    take();
    check("R6 same group no nest", int'(take_valid), 0);
    ret();
    check("R6 next winner", int'(take_num), 18);
    take(); ret();
    check("R6 last winner", int'(take_num), 16);
    take(); ret();
    wr(0, 0);

    // R8 global mask and fixed exceptions, R4 fixed order
    wr(0, 1);
    irq_reg(0, 1, 1, 0);
    check("R8 masked", int'(take_valid), 0);
    nmi_in = 1'b1; hfault_in = 1'b1;
    tick();
    check("R4 nmi over hfault", int'(take_num), 1);
    take();
    check("R5 hfault below nmi", int'(take_valid), 0);
    ret();
    check("R2 hfault number", int'(take_num), 2);
    take(); ret();
    nmi_in = 1'b0; hfault_in = 1'b0;
    check("R8 still masked", int'(take_valid), 0);
    wr(0, 0);
    check("R8 unmasked", int'(take_num), 16);
    take();
    hfault_in = 1'b1; tick();
    check("R5 hfault preempts prio0", int'(take_num), 2);
    take(); ret(); ret();
    hfault_in = 1'b0;
    irq_reg(0, 0, 0, 0);

    // R3 edge detection and software pending
    irq_reg(2, 1, 0, 4);
    irq_in[2] = 1'b1; tick();
    check("R3 rising edge", int'(take_num), 18);
    take(); ret(); tick();
    check("R3 held level", int'(take_valid), 0);
    irq_in[2] = 1'b0; tick();
    irq_in[2] = 1'b1; tick();
    check("R3 second edge", int'(take_num), 18);
    take(); ret();
    irq_in[2] = 1'b0;
    irq_reg(3, 1, 1, 2);
    check("R3 sw set", int'(take_num), 19);
    irq_reg(3, 1, 0, 2);
    check("R3 sw clear", int'(take_valid), 0);
    irq_reg(2, 0, 0, 0);
    irq_reg(3, 0, 0, 0);

    // R12 register readback, R9 active bit
    irq_reg(1, 1, 0, 5);
    rd(257, v); check("R12 readback", v, 16'h0501);
    irq_reg(1, 1, 1, 5);
    take();
    rd(257, v); check("R9 active set pend clear", v, 16'h0505);
    ret();
    rd(257, v); check("R10 active cleared", v, 16'h0501);
    irq_reg(1, 0, 1, 5);
    check("R12 disabled not offered", int'(take_valid), 0);
    rd(257, v); check("R12 disabled pending", v, 16'h0502);
    irq_reg(1, 0, 0, 0);

    // R10 innermost return
    irq_reg(0, 1, 1, 6);
    take();
    irq_reg(1, 1, 1, 2);
    check("R5 nest", int'(take_num), 17);
    take();
    irq_reg(2, 1, 1, 4);
    check("R5 blocked by inner", int'(take_valid), 0);
    ret();
    check("R10 recomputed", int'(take_num), 18);
    take(); ret(); ret();
    rd(256, v); check("R10 outer cleared", v & 4, 0);
    irq_reg(0, 0, 0, 0); irq_reg(1, 0, 0, 0); irq_reg(2, 0, 0, 0);

    // R11 sleep-on-exit
    irq_reg(0, 1, 1, 3);
    take(); ret();
    check("R11 disabled no sleep", int'(sleep_req), 0);
    wr(0, 2);
    irq_reg(0, 1, 1, 3);
    take();
    check("R11 no sleep while active", int'(sleep_req), 0);
    ret();
    check("R11 sleep", int'(sleep_req), 1);
    irq_reg(1, 1, 1, 6);
    check("R11 offer present", int'(take_num), 17);
    tick();
    check("R11 sleep cleared", int'(sleep_req), 0);
    take();
    irq_reg(0, 1, 1, 7);
    ret();
    check("R11 pending blocks sleep", int'(sleep_req), 0);
    check("R11 pending offered", int'(take_num), 16);
    take(); ret();
    check("R11 sleep again", int'(sleep_req), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule